// File: doc/BRIEF.md
# Phase-Leg Gate Sequencer with Capacitor-Correcting Switch Selection

This block drives the five switches of one phase leg of a coupled rectifier/inverter cell. The rectifier half is the master: its direction bit alone fixes the shared switch S2 for the whole switching period. The inverter half then reaches its output level through one of several redundant switch combinations. The S4/S5 pair is the only part of the leg that moves charge in the inverter's floating capacitor. For each segment of the period, the block picks the combination whose S4/S5 pair pushes that capacitor back toward its setpoint, given the sign of the inverter current.

A free-running counter sets the switching period. At the start of every period the block captures the two sign bits, the capacitor-above-setpoint bit, the current sign and the two on-time durations. It holds all of them until the next boundary. Each gate is then a two-segment waveform that compares the counter against that gate's latched limit. The durations come from an outside modulator, and dead time is added downstream.

Top module: `leg_gate_sequencer`

## Requirements
- R1: While `rst_n` is low, every gate is inactive, and `uncontrollable` and `period_start` are low.
- R2: `period_start` is high for exactly one cycle every PERIOD = CLK_HZ/SW_HZ cycles, first on the first clock after reset. All inputs are captured on the edge that raises `period_start`, and changes later in the period have no effect.
- R3: Gate bit 0 (S1) is high for the first `t_rec` cycles of the period. A duration above PERIOD acts as PERIOD.
- R4: Gate bit 1 (S2) is constant over the period: low when `rec_ref_pos` was 1 (rectifier P/O) and high when it was 0 (rectifier O/N).
- R5: The inverter level (S3 − S2 + S5 − S4), with S3/S4/S5 on gate bits 2/3/4, is +1 during the first `t_inv` cycles and 0 afterwards when `inv_ref_pos` was 1. When `inv_ref_pos` was 0, it is 0 during the first `t_inv` cycles and −1 afterwards. A duration above PERIOD acts as PERIOD.
- R6: The wanted pair sign is +1 (S5=1, S4=0) when `cap_over` equals `inv_cur_pos`, and −1 (S5=0, S4=1) otherwise. This pair discharges an over-voltage capacitor and charges an under-voltage one. Whenever the segment's level can be reached with the wanted pair, that pair is used.
- R7: When the wanted pair cannot reach the level, the hold pair S4 = S5 = S2 is used if possible. Otherwise the opposite pair is forced so that the level of R5 is still produced.
- R8: `uncontrollable` is high for the whole period exactly when a segment of non-zero length needs the forced pair of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_ref_pos | input | 1 | Sign of offset rectifier reference (1 = positive) |
| inv_ref_pos | input | 1 | Sign of offset inverter reference (1 = positive) |
| cap_over | input | 1 | Inverter capacitor above its setpoint |
| inv_cur_pos | input | 1 | Inverter current positive (0 = zero or negative) |
| t_rec | input | CNT_W | Rectifier duration in cycles |
| t_inv | input | CNT_W | Inverter duration in cycles |
| gate | output | 5 | Gate drives, bit k = switch S(k+1), active high by default |
| period_start | output | 1 | First cycle of a switching period |
| uncontrollable | output | 1 | Capacitor correction impossible this period |

## Verification
Two events can land on the same clock: the reload of the latched plan at the period boundary, and a change of inverter segment. With `t_inv` set to 0 or to PERIOD, the segment boundary falls on the reload cycle, so one segment is empty and must not raise `uncontrollable`. The bench drives these cases and, one cycle after each reload, scrambles every input, so a design that reads live inputs shows up at once. A behavioural model recomputes each gate, the inverter level, the flag and the period pulse every cycle, and they are compared on every clock.

// File: rtl/leg_gate_pkg.sv
package leg_gate_pkg;

   // inverter level requested for one segment of the period
   typedef enum logic [1:0] {
      LVL_ZERO = 2'b00,
      LVL_POS  = 2'b01,
      LVL_NEG  = 2'b10
   } lvl_e;

   // how a segment's combination was reached
   typedef enum logic [1:0] {
      PICK_CORRECT = 2'd0,
      PICK_HOLD    = 2'd1,
      PICK_FORCED  = 2'd2
   } pick_e;

   typedef struct packed {
      logic s3;
      logic s4;
      logic s5;
   } inv_sw_t;

   localparam int NUM_GATES = 5;
   localparam int IDX_S1    = 0;
   localparam int IDX_S2    = 1;
   localparam int IDX_S3    = 2;
   localparam int IDX_S4    = 3;
   localparam int IDX_S5    = 4;
   localparam int NUM_SEGS  = 2;

endpackage

// File: rtl/leg_period_timer.sv
module leg_period_timer #(
   parameter int PERIOD = 10000,
   parameter int CNT_W  = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             start
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   assign wrap  = (cnt == LAST);
   assign start = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= LAST;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/leg_combo_select.sv
module leg_combo_select
   import leg_gate_pkg::*;
(
   input  logic    s2,
   input  lvl_e    lvl,
   input  logic    want_pos,
   output inv_sw_t sw,
   output pick_e   kind
);

   always_comb begin
      sw   = '{s3: s2, s4: s2, s5: s2};
      kind = PICK_HOLD;
      case (lvl)
         LVL_POS: begin
            if (want_pos) begin
               sw   = '{s3: s2, s4: 1'b0, s5: 1'b1};
               kind = PICK_CORRECT;
            end else if (!s2) begin
               sw   = '{s3: 1'b1, s4: 1'b0, s5: 1'b0};
               kind = PICK_HOLD;
            end else begin
               sw   = '{s3: 1'b1, s4: 1'b0, s5: 1'b1};
               kind = PICK_FORCED;
            end
         end
         LVL_ZERO: begin
            if (want_pos && s2) begin
               sw   = '{s3: 1'b0, s4: 1'b0, s5: 1'b1};
               kind = PICK_CORRECT;
            end else if (!want_pos && !s2) begin
               sw   = '{s3: 1'b1, s4: 1'b1, s5: 1'b0};
               kind = PICK_CORRECT;
            end else begin
               sw   = '{s3: s2, s4: s2, s5: s2};
               kind = PICK_HOLD;
            end
         end
         LVL_NEG: begin
            if (!want_pos) begin
               sw   = '{s3: s2, s4: 1'b1, s5: 1'b0};
               kind = PICK_CORRECT;
            end else if (s2) begin
               sw   = '{s3: 1'b0, s4: 1'b1, s5: 1'b1};
               kind = PICK_HOLD;
            end else begin
               sw   = '{s3: 1'b0, s4: 1'b1, s5: 1'b0};
               kind = PICK_FORCED;
            end
         end
         default: begin
            sw   = '{s3: s2, s4: s2, s5: s2};
            kind = PICK_HOLD;
         end
      endcase
   end

endmodule

// File: rtl/leg_edge_shaper.sv
module leg_edge_shaper #(
   parameter int CNT_W       = 14,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] lim,
   input  logic             first_v,
   input  logic             rest_v,
   output logic             gate_o
);

   logic raw;

   assign raw = (cnt < lim) ? first_v : rest_v;

   generate
      if (ACTIVE_HIGH) begin : g_pos
         assign gate_o = raw;
      end else begin : g_neg
         assign gate_o = ~raw;
      end
   endgenerate

endmodule

// File: rtl/leg_gate_sequencer.sv
module leg_gate_sequencer
   import leg_gate_pkg::*;
#(
   parameter int   CLK_HZ           = 50_000_000,
   parameter int   SW_HZ            = 5_000,
   parameter bit   GATE_ACTIVE_HIGH = 1'b1,
   localparam int  PERIOD           = CLK_HZ / SW_HZ,
   localparam int  CNT_W            = $clog2(PERIOD + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rec_ref_pos,
   input  logic                 inv_ref_pos,
   input  logic                 cap_over,
   input  logic                 inv_cur_pos,
   input  logic [CNT_W-1:0]     t_rec,
   input  logic [CNT_W-1:0]     t_inv,
   output logic [NUM_GATES-1:0] gate,
   output logic                 period_start,
   output logic                 uncontrollable
);

   localparam logic [CNT_W-1:0] PERIOD_W = CNT_W'(PERIOD);

   generate
      if (SW_HZ <= 0 || (CLK_HZ % SW_HZ) != 0 || PERIOD < 2) begin : g_bad_cfg
         $error("leg_gate_sequencer: CLK_HZ must be a multiple of SW_HZ with at least two cycles per period");
      end
   endgenerate

   // ---------------- period timer ----------------
   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic             start;

   leg_period_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .wrap  (wrap),
      .start (start)
   );

   // ---------------- next-period plan ----------------
   logic [CNT_W-1:0]   t_rec_c;
   logic [CNT_W-1:0]   t_inv_c;
   logic               s2_next;
   logic               want_pos;
   lvl_e               seg_lvl  [NUM_SEGS];
   inv_sw_t            seg_sw   [NUM_SEGS];
   pick_e              seg_kind [NUM_SEGS];
   logic [NUM_SEGS-1:0] seg_live;
   logic [NUM_SEGS-1:0] seg_forced;
   logic               unc_next;

   assign t_rec_c  = (t_rec > PERIOD_W) ? PERIOD_W : t_rec;
   assign t_inv_c  = (t_inv > PERIOD_W) ? PERIOD_W : t_inv;
   assign s2_next  = ~rec_ref_pos;
   assign want_pos = ~(cap_over ^ inv_cur_pos);

   assign seg_lvl[0]  = inv_ref_pos ? LVL_POS  : LVL_ZERO;
   assign seg_lvl[1]  = inv_ref_pos ? LVL_ZERO : LVL_NEG;
   assign seg_live[0] = (t_inv_c != '0);
   assign seg_live[1] = (t_inv_c != PERIOD_W);

   generate
      for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
         leg_combo_select u_sel (
            .s2       (s2_next),
            .lvl      (seg_lvl[s]),
            .want_pos (want_pos),
            .sw       (seg_sw[s]),
            .kind     (seg_kind[s])
         );
         assign seg_forced[s] = (seg_kind[s] == PICK_FORCED);
      end
   endgenerate

   assign unc_next = |(seg_forced & seg_live);

   // ---------------- plan register ----------------
   logic             s2_q;
   logic [CNT_W-1:0] t_rec_q;
   logic [CNT_W-1:0] t_inv_q;
   inv_sw_t          sw_first_q;
   inv_sw_t          sw_rest_q;
   logic             unc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_q       <= 1'b0;
         t_rec_q    <= '0;
         t_inv_q    <= '0;
         sw_first_q <= '0;
         sw_rest_q  <= '0;
         unc_q      <= 1'b0;
      end else if (wrap) begin
         s2_q       <= s2_next;
         t_rec_q    <= t_rec_c;
         t_inv_q    <= t_inv_c;
         sw_first_q <= seg_sw[0];
         sw_rest_q  <= seg_sw[1];
         unc_q      <= unc_next;
      end
   end

   // ---------------- gate shaping ----------------
   logic [CNT_W-1:0]     shp_lim [NUM_GATES];
   logic [NUM_GATES-1:0] shp_first;
   logic [NUM_GATES-1:0] shp_rest;

   always_comb begin
      shp_lim[IDX_S1]   = t_rec_q;
      shp_first[IDX_S1] = 1'b1;
      shp_rest[IDX_S1]  = 1'b0;
      shp_lim[IDX_S2]   = t_inv_q;
      shp_first[IDX_S2] = s2_q;
      shp_rest[IDX_S2]  = s2_q;
      shp_lim[IDX_S3]   = t_inv_q;
      shp_first[IDX_S3] = sw_first_q.s3;
      shp_rest[IDX_S3]  = sw_rest_q.s3;
      shp_lim[IDX_S4]   = t_inv_q;
      shp_first[IDX_S4] = sw_first_q.s4;
      shp_rest[IDX_S4]  = sw_rest_q.s4;
      shp_lim[IDX_S5]   = t_inv_q;
      shp_first[IDX_S5] = sw_first_q.s5;
      shp_rest[IDX_S5]  = sw_rest_q.s5;
   end

   generate
      for (genvar k = 0; k < NUM_GATES; k++) begin : g_gate
         leg_edge_shaper #(.CNT_W(CNT_W), .ACTIVE_HIGH(GATE_ACTIVE_HIGH)) u_shp (
            .cnt     (cnt),
            .lim     (shp_lim[k]),
            .first_v (shp_first[k]),
            .rest_v  (shp_rest[k]),
            .gate_o  (gate[k])
         );
      end
   endgenerate

   assign period_start   = start;
   assign uncontrollable = unc_q;

endmodule

// File: rtl/leg_gate_checker.sv
module leg_gate_checker #(
   parameter int PERIOD   = 2,
   parameter bit ACT_HIGH = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] gate,
   input logic       period_start,
   input logic       uncontrollable
);

   logic [4:0]  raw;
   int unsigned gap;
   logic        seen;

   assign raw = ACT_HIGH ? gate : ~gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (period_start) begin
         gap  <= 0;
         seen <= 1'b1;
      end else begin
         gap  <= gap + 1;
      end
   end

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_idle_chk: assert (raw == 5'b0 && !uncontrollable && !period_start);
      end
   end

   // R2
   period_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start && seen) |-> (gap == PERIOD - 1));

   // R3
   s1_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |-> !$rose(raw[0]));

   // R4
   s2_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |-> $stable(raw[1]));

   // R5
   level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((raw[2] && !raw[1] && raw[4] && !raw[3]) ||
        (!raw[2] && raw[1] && !raw[4] && raw[3])));

   // R8
   unc_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |-> $stable(uncontrollable));

endmodule

bind leg_gate_sequencer leg_gate_checker #(
   .PERIOD   (PERIOD),
   .ACT_HIGH (GATE_ACTIVE_HIGH)
) u_leg_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .gate           (gate),
   .period_start   (period_start),
   .uncontrollable (uncontrollable)
);

// File: tb/test_leg_gate_sequencer.sv
module test_leg_gate_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 200_000;
   localparam int SW_HZ      = 5_000;
   localparam int PERIOD     = CLK_HZ / SW_HZ;
   localparam int CNT_W      = $clog2(PERIOD + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rec_ref_pos = 1'b0;
   logic             inv_ref_pos = 1'b0;
   logic             cap_over = 1'b0;
   logic             inv_cur_pos = 1'b0;
   logic [CNT_W-1:0] t_rec = '0;
   logic [CNT_W-1:0] t_inv = '0;
   logic [4:0]       gate;
   logic             period_start;
   logic             uncontrollable;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit armed = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   leg_gate_sequencer #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ)) i_leg_gate_sequencer (
      .clk            (clk),
      .rst_n          (rst_n),
      .rec_ref_pos    (rec_ref_pos),
      .inv_ref_pos    (inv_ref_pos),
      .cap_over       (cap_over),
      .inv_cur_pos    (inv_cur_pos),
      .t_rec          (t_rec),
      .t_inv          (t_inv),
      .gate           (gate),
      .period_start   (period_start),
      .uncontrollable (uncontrollable)
   );

   // ---------------- behavioural reference ----------------
   int m_cnt = PERIOD - 1;
   int p_s2 = 0, p_tr = 0, p_ti = 0, p_unc = 0;
   int p_lv[2]   = '{0, 0};
   int p_s3[2]   = '{0, 0};
   int p_s4[2]   = '{0, 0};
   int p_s5[2]   = '{0, 0};
   int p_kind[2] = '{1, 1};

   // kind: 0 corrective, 1 hold, 2 forced
   task automatic pick(input int s2, input int lvl, input int d,
                       output int s3, output int s4, output int s5, output int kind);
      int cand[3];
      cand = '{d, 0, -d};
      kind = -1;
      s3 = 0; s4 = 0; s5 = 0;
      for (int i = 0; i < 3; i++) begin
         int t;
         t = lvl - cand[i] + s2;
         if (kind < 0 && (t == 0 || t == 1)) begin
            kind = i;
            s3 = t;
            if (cand[i] > 0)      begin s4 = 0;  s5 = 1;  end
            else if (cand[i] < 0) begin s4 = 1;  s5 = 0;  end
            else                  begin s4 = s2; s5 = s2; end
         end
      end
   endtask

   always @(posedge clk) begin
      armed = 1'b1;
      if (!rst_n) begin
         m_cnt = PERIOD - 1;
         p_s2 = 0; p_tr = 0; p_ti = 0; p_unc = 0;
         for (int s = 0; s < 2; s++) begin
            p_lv[s] = 0; p_s3[s] = 0; p_s4[s] = 0; p_s5[s] = 0; p_kind[s] = 1;
         end
      end else if (m_cnt == PERIOD - 1) begin
         int d;
         m_cnt = 0;
         p_s2  = rec_ref_pos ? 0 : 1;
         p_tr  = (int'(t_rec) > PERIOD) ? PERIOD : int'(t_rec);
         p_ti  = (int'(t_inv) > PERIOD) ? PERIOD : int'(t_inv);
         d     = (inv_cur_pos ? 1 : -1) * (cap_over ? 1 : -1);
         p_lv[0] = inv_ref_pos ? 1 : 0;
         p_lv[1] = inv_ref_pos ? 0 : -1;
         for (int s = 0; s < 2; s++)
            pick(p_s2, p_lv[s], d, p_s3[s], p_s4[s], p_s5[s], p_kind[s]);
         p_unc = ((p_kind[0] == 2 && p_ti > 0) || (p_kind[1] == 2 && p_ti < PERIOD)) ? 1 : 0;
      end else begin
         m_cnt++;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (armed && !done) begin
         if (!rst_n) begin
            chk("R1", "gates in reset", int'(gate), 0);
            chk("R1", "flag in reset", int'(uncontrollable), 0);
            chk("R1", "start in reset", int'(period_start), 0);
         end else begin
            int seg, lvl_act;
            seg = (m_cnt < p_ti) ? 0 : 1;
            chk("R2", "period_start", int'(period_start), (m_cnt == 0) ? 1 : 0);
            chk("R3", "S1", int'(gate[0]), (m_cnt < p_tr) ? 1 : 0);
            chk("R4", "S2", int'(gate[1]), p_s2);
            lvl_act = int'(gate[2]) - int'(gate[1]) + int'(gate[4]) - int'(gate[3]);
            chk("R5", "inverter level", lvl_act, p_lv[seg]);
            if (p_kind[seg] == 0) begin
               chk("R6", "S3", int'(gate[2]), p_s3[seg]);
               chk("R6", "S4", int'(gate[3]), p_s4[seg]);
               chk("R6", "S5", int'(gate[4]), p_s5[seg]);
            end else begin
               chk("R7", "S3", int'(gate[2]), p_s3[seg]);
               chk("R7", "S4", int'(gate[3]), p_s4[seg]);
               chk("R7", "S5", int'(gate[4]), p_s5[seg]);
            end
            chk("R8", "uncontrollable", int'(uncontrollable), p_unc);
         end
      end
   end

   // drive one period's inputs just before the boundary, scramble right after
   task automatic run(input bit rp, input bit ip, input bit co, input bit cp,
                      input int tr, input int ti);
      while (m_cnt != PERIOD - 1) @(negedge clk);
      rec_ref_pos = rp; inv_ref_pos = ip; cap_over = co; inv_cur_pos = cp;
      t_rec = CNT_W'(tr); t_inv = CNT_W'(ti);
      @(negedge clk);
      // R2: these must not reach the current period
      rec_ref_pos = ~rp; inv_ref_pos = ~ip; cap_over = ~co; inv_cur_pos = ~cp;
      t_rec = CNT_W'(tr) ^ CNT_W'(21); t_inv = CNT_W'(ti) ^ CNT_W'(13);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      run(1, 1, 1, 1, 13, 27);          // R6: rectifier P/O, inverter P/O, discharge, positive current
      run(0, 0, 1, 0, 9, 31);           // R6 R7: rectifier O/N, inverter O/N, negative current
      for (int c = 0; c < 16; c++)
         run(c[3], c[2], c[1], c[0], 13, 27);
      run(0, 1, 1, 0, 20, 20);          // R7 R8: forced in first segment
      run(1, 0, 0, 0, 20, 20);          // R7 R8: forced in rest segment
      run(1, 0, 0, 0, 20, 40);          // R8: forced segment empty
      run(0, 1, 1, 0, 11, 0);           // R8: forced segment empty at zero
      run(1, 1, 0, 1, 0, 0);            // R3 R5: zero durations
      run(0, 0, 1, 1, 40, 40);          // R3 R5: full durations
      run(1, 0, 1, 0, 63, 50);          // R3 R5: clamp above period
      run(0, 1, 0, 1, 1, 39);
      run(1, 0, 1, 1, 39, 1);
      run(1, 1, 1, 1, 5, 5);
      while (m_cnt != PERIOD - 1) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule